// File: doc/BRIEF.md
# Low-Speed USB Serial Packet Receiver

This block sits behind the two data lines of a low-speed USB port. It passes both lines through a two-flop synchroniser. It runs on a clock at `OVS` times the bit rate, which is 12 MHz for the 1.5 Mbit/s bus with the default of 8. A phase counter restarts on every line transition and picks one sample per bit near the bit centre.

A small state machine watches those samples for the end of the sync pattern. The packet begins only when two K bits arrive in a row. A single K followed by J returns the block to hunting. Inside a packet each sample is NRZI-decoded against a reference line state. After six decoded ones the next bit is dropped as a stuff bit. Data bits are shifted in LSB first, and every completed byte is presented with a one-cycle write strobe.

SE0 during a packet closes it. The block then reports either a done pulse with the byte count or, when more bytes came than the buffer holds, an overflow pulse and no done.

Top module: `lsusb_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_en`, `done` and `overflow` are 0.
- R2: Line states are encoded {D+, D-}: J = 01 (idle), K = 10, SE0 = 00. A packet starts only after two consecutive K samples. A K sample followed by a J sample starts nothing: it produces no write, no done and no overflow.
- R3: Inside a packet, a sample equal to the reference state decodes as 1. A differing sample decodes as 0 and becomes the new reference. The reference is K when the packet starts.
- R4: After six consecutive decoded 1s the next sample is a stuff bit. It is not data, it becomes the reference, and it clears the ones count. This holds when the stuff bit falls after bit 6 or bit 7 of a byte or across a byte boundary, and byte alignment is kept.
- R5: Bits are assembled LSB first (the first data bit is `wr_data[0]`). Each completed byte gives a `wr_en` pulse one cycle wide with the byte on `wr_data`.
- R6: An SE0 sample inside a packet ends it. On the next cycle `done` pulses with `done_count` equal to the number of bytes written, which may be 0. Incomplete bits are discarded.
- R7: If a byte completes after `BUF_DEPTH` bytes have been written, no further writes happen. At SE0 `overflow` pulses instead of `done`.
- R8: The sample point restarts on each line transition and sits `OVS/2` clocks after it, so reception works for any start phase of the packet relative to the clock.
- R9: After an overflowed or rejected packet, the next valid packet is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OVS` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dn | input | 1 | D- line, asynchronous |
| wr_en | output | 1 | One-cycle strobe for a received byte |
| wr_data | output | 8 | Received byte, valid with `wr_en` |
| done | output | 1 | One-cycle pulse: packet ended within the buffer size |
| done_count | output | $clog2(BUF_DEPTH+1) | Bytes in the finished packet, valid with `done` |
| overflow | output | 1 | One-cycle pulse: packet ended after exceeding `BUF_DEPTH` bytes |

## Verification
Runs of 0xFF bytes push the stuff bit across a byte boundary and right after bit 7. A 0x7E byte places it right after bit 6. A receiver that unstuffs late or miscounts ones across bytes would shift every following byte by one bit. Sync fragments that end in K then J check that a false start produces no write. A design that started on a single K would emit junk bytes. Packets of exactly `BUF_DEPTH` and `BUF_DEPTH+1` bytes separate a correct done from an overflow. An off-by-one limit would drop a legal byte or accept an extra one. Each packet also starts at a random clock phase, which exposes a sample point that does not re-centre.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

    // Line state encoded as {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GOTK,
        ST_DATA
    } rx_state_e;

    // Number of decoded ones after which a stuff bit follows
    localparam int STUFF_RUN = 6;

    // Result of one decoded sample
    typedef struct packed {
        logic is_stuff;
        logic bit_val;
    } dec_t;

    function automatic dec_t decode_sample(line_e smp, line_e ref_ln, logic [2:0] ones);
        dec_t d;
        d.is_stuff = (ones == 3'(STUFF_RUN));
        d.bit_val  = (smp == ref_ln);
        return d;
    endfunction

endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lsrx_phase.sv
module lsrx_phase
    import lsrx_pkg::*;
#(
    parameter int OVS = 8,
    localparam int PW = $clog2(OVS)
) (
    input  logic  clk,
    input  logic  rst,
    input  line_e ln,
    output logic  strobe
);
    localparam logic [PW-1:0] CENTRE = PW'(OVS / 2);
    localparam logic [PW-1:0] LAST   = PW'(OVS - 1);

    line_e         prev_ln;
    logic [PW-1:0] ph;
    logic          edge_seen;

    assign edge_seen = (ln != prev_ln);
    assign strobe    = !edge_seen && (ph == CENTRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ln <= LN_J;
            ph      <= '0;
        end else begin
            prev_ln <= ln;
            if (edge_seen)
                ph <= PW'(1);
            else if (ph == LAST)
                ph <= '0;
            else
                ph <= ph + PW'(1);
        end
    end

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R8

endmodule

// File: rtl/lsrx_core.sv
module lsrx_core
    import lsrx_pkg::*;
#(
    parameter int BUF_DEPTH = 11,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  line_e         smp,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic [CW-1:0] done_count,
    output logic          overflow
);
    rx_state_e     state;
    line_e         ref_ln;
    logic [2:0]    ones;
    logic [6:0]    shreg;
    logic [2:0]    bitn;
    logic [CW-1:0] count;
    logic          ovf;
    dec_t          dec;

    always_comb dec = decode_sample(smp, ref_ln, ones);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ref_ln     <= LN_K;
            ones       <= '0;
            shreg      <= '0;
            bitn       <= '0;
            count      <= '0;
            ovf        <= 1'b0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            done       <= 1'b0;
            done_count <= '0;
            overflow   <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            done     <= 1'b0;
            overflow <= 1'b0;
            if (strobe) begin
                unique case (state)
                    ST_IDLE: begin
                        if (smp == LN_K) state <= ST_GOTK;
                    end
                    ST_GOTK: begin
                        if (smp == LN_K) begin
                            state  <= ST_DATA;
                            ref_ln <= LN_K;
                            ones   <= '0;
                            bitn   <= '0;
                            count  <= '0;
                            ovf    <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        if (smp == LN_SE0) begin
                            state <= ST_IDLE;
                            if (ovf) begin
                                overflow <= 1'b1;
                            end else begin
                                done       <= 1'b1;
                                done_count <= count;
                            end
                        end else if (dec.is_stuff) begin
                            ref_ln <= smp;
                            ones   <= '0;
                        end else begin
                            if (dec.bit_val) begin
                                ones <= ones + 3'd1;
                            end else begin
                                ref_ln <= smp;
                                ones   <= '0;
                            end
                            shreg <= {dec.bit_val, shreg[6:1]};
                            bitn  <= bitn + 3'd1;
                            if (bitn == 3'd7 && !ovf) begin
                                if (count == CW'(BUF_DEPTH)) begin
                                    ovf <= 1'b1;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_data <= {dec.bit_val, shreg};
                                    count   <= count + CW'(1);
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R5
    AST_WR_IN_PACKET: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> state == ST_DATA); // R2
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> !overflow); // R7
    AST_END_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        (done || overflow) |-> $past(state) == ST_DATA); // R6
    AST_ONES_CAP: assert property (@(posedge clk) disable iff (rst)
        ones <= 3'(STUFF_RUN)); // R4

endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
    import lsrx_pkg::*;
#(
    parameter int  OVS       = 8,
    parameter int  BUF_DEPTH = 11,
    localparam int CW        = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          usb_dp,
    input  logic          usb_dn,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic [CW-1:0] done_count,
    output logic          overflow
);
    logic [1:0] lines_s;
    line_e      ln;
    logic       strobe;

    lsrx_sync #(.W(2), .RST_VAL(2'b01)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({usb_dp, usb_dn}),
        .q   (lines_s)
    );

    assign ln = line_e'(lines_s);

    lsrx_phase #(.OVS(OVS)) i_phase (
        .clk    (clk),
        .rst    (rst),
        .ln     (ln),
        .strobe (strobe)
    );

    lsrx_core #(.BUF_DEPTH(BUF_DEPTH)) i_core (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .smp        (ln),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .done       (done),
        .done_count (done_count),
        .overflow   (overflow)
    );

endmodule

// File: tb/test_lsusb_rx.sv
module test_lsusb_rx;
    localparam int OVS   = 8;
    localparam int DEPTH = 11;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dp  = 1'b0;
    logic          dn  = 1'b1;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic          done;
    logic [CW-1:0] done_count;
    logic          overflow;

    int checks = 0;
    int fails  = 0;

    logic [7:0] tx [0:31];
    logic [7:0] rx [0:31];
    int rxn = 0;
    int got_done = 0;
    int got_ovf = 0;
    int got_cnt = 0;

    always #2 clk = ~clk;

    lsusb_rx #(.OVS(OVS), .BUF_DEPTH(DEPTH)) i_lsusb_rx (
        .clk(clk), .rst(rst), .usb_dp(dp), .usb_dn(dn),
        .wr_en(wr_en), .wr_data(wr_data), .done(done),
        .done_count(done_count), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                if (rxn < 32) rx[rxn] = wr_data;
                rxn++;
            end
            if (done) begin
                got_done++;
                got_cnt = int'(done_count);
            end
            if (overflow) got_ovf++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // line: 2'b01 J, 2'b10 K, 2'b00 SE0
    task automatic hold(input logic [1:0] l, input int ncyc);
        {dp, dn} = l;
        repeat (ncyc) @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [1:0] l);
        hold(l, OVS);
    endtask

    function automatic logic [1:0] flip(input logic [1:0] l);
        return (l == 2'b01) ? 2'b10 : 2'b01;
    endfunction

    task automatic clear_mon();
        rxn = 0; got_done = 0; got_ovf = 0; got_cnt = 0;
    endtask

    task automatic send_pkt(input int n);
        logic [1:0] cur;
        int ones;
        hold(2'b01, 16 + int'($urandom_range(0, 7)));   // random start phase (R8)
        for (int i = 0; i < 8; i++) put((i % 2 == 1 && i < 6) ? 2'b01 : 2'b10);
        cur = 2'b10;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (tx[i][b]) begin
                    put(cur);
                    ones++;
                    if (ones == 6) begin
                        cur = flip(cur);
                        put(cur);
                        ones = 0;
                    end
                end else begin
                    cur = flip(cur);
                    put(cur);
                    ones = 0;
                end
            end
        end
        put(2'b00);
        put(2'b00);
        hold(2'b01, 3 * OVS);
    endtask

    task automatic run_and_check(input int n, input string tag);
        int exp_w;
        int bad;
        clear_mon();
        send_pkt(n);
        exp_w = (n <= DEPTH) ? n : DEPTH;
        chk(rxn == exp_w, {tag, " R5 write count"}, rxn, exp_w);
        bad = 0;
        for (int i = 0; i < exp_w && i < rxn; i++)
            if (rx[i] !== tx[i]) begin
                bad++;
                $display("FAIL %s R3/R4 byte %0d actual=%02h expected=%02h", tag, i, rx[i], tx[i]);
            end
        checks++;
        if (bad != 0) fails++;
        if (n <= DEPTH) begin
            chk(got_done == 1 && got_ovf == 0, {tag, " R6 done pulse"}, got_done, 1);
            chk(got_cnt == n, {tag, " R6 done_count"}, got_cnt, n);
        end else begin
            chk(got_ovf == 1 && got_done == 0, {tag, " R7 overflow pulse"}, got_ovf, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        #1;
        chk(!wr_en && !done && !overflow, "R1 outputs in reset", int'({wr_en, done, overflow}), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(!wr_en && !done && !overflow, "R1 outputs after reset", int'({wr_en, done, overflow}), 0);
        hold(2'b01, 20);

        // R4: three 0xFF bytes put a stuff bit right after bit 7
        for (int i = 0; i < 3; i++) tx[i] = 8'hFF;
        run_and_check(3, "ff_run R4");

        // R4: 0x7E places a stuff bit right after bit 6
        tx[0] = 8'h7E; tx[1] = 8'h00; tx[2] = 8'h81;
        run_and_check(3, "bit6_stuff R4");

        // R6: empty packet
        run_and_check(0, "empty R6");

        // R2: false sync, K then J, then idle and SE0
        clear_mon();
        hold(2'b01, 20);
        put(2'b10); put(2'b01); put(2'b10); put(2'b01); put(2'b01); put(2'b01);
        put(2'b00); put(2'b00);
        hold(2'b01, 3 * OVS);
        chk(rxn == 0 && got_done == 0 && got_ovf == 0, "R2 false sync ignored", rxn + got_done + got_ovf, 0);

        // R9: valid packet after a rejected start
        tx[0] = 8'hA5; tx[1] = 8'h3C;
        run_and_check(2, "after_false R9");

        // R7: exactly full and one over
        for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
        run_and_check(DEPTH, "full R7");
        run_and_check(DEPTH + 1, "over R7");
        run_and_check(DEPTH + 4, "over4 R7");

        // R9: recovery after overflow
        tx[0] = 8'h01; tx[1] = 8'h80;
        run_and_check(2, "after_ovf R9");

        // R3 R5 R8: random packets with random phase and bias toward 0xFF
        for (int p = 0; p < 10; p++) begin
            int n;
            n = int'($urandom_range(1, DEPTH));
            for (int i = 0; i < n; i++)
                tx[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
            run_and_check(n, "random R3 R8");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule